// File: doc/BRIEF.md
# Pause Stretcher for Sampled Speech

The block sits in a sampled speech path and lengthens the pauses between words. Each input sample arrives with a one-cycle strobe. A small silence detector counts how many low-level samples have arrived in a row. When delay insertion is selected and a run of quiet samples is long enough to be a real pause, the block sends a burst of zero samples to the output. The input samples that arrive during that burst are kept in a circular store, so none is lost. Afterwards the output runs behind the input by the total number of zeros inserted so far.

The lag only ever grows, one zero at a time, and only inside detected pauses. The size of the circular store sets the largest lag. A flush selection drops all of the lag at once, and the stream then passes straight through again. For every input strobe the block produces exactly one output sample. That sample is the oldest stored one, the input itself when nothing is stored, or an inserted zero.

Top module: `pause_stretcher`

## Requirements
- R1: Each cycle with `inValid` high produces `outValid` high on the following cycle, with its sample on `outData`. `outValid` is low in every other cycle, and it is low with `outData` zero after reset.
- R2: With `modeSel` = 2'b00 and no accumulated lag, `outData` equals the input sample of the previous strobe.
- R3: A sample is quiet when its two's-complement magnitude is below 768, so both 768 and -768 count as loud. Any loud sample clears the quiet-run count to zero. The count saturates at 80.
- R4: With `modeSel` = 2'b01, the strobe that brings the quiet run from 79 to 80 arms a stretch of 80 zeros. That strobe itself is passed on normally, and the zeros start on the next strobe.
- R5: During a stretch each output sample is exactly zero. Every input sample accepted during the stretch is later delivered, in arrival order and unchanged.
- R6: The lag (stored samples) grows by one only for each inserted zero. In any mode other than 2'b10, outside insertion the output is the oldest stored sample, so the stream is delayed by the accumulated lag.
- R7: The lag never exceeds 2^ADDR_W - 1 samples. Once it reaches that limit, no further zeros are inserted and the samples pass through with that lag.
- R8: With `modeSel` = 2'b10 the lag becomes zero and any pending stretch is cancelled. A sample strobed in that mode is passed through directly. Code 2'b11 behaves as 2'b00.
- R9: Selecting any mode other than 2'b01 cancels the remaining zeros of a stretch in progress. Arming a new stretch then needs a fresh quiet run, which starts after a loud sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Input sample strobe |
| inData | input | DATA_W | Signed input sample |
| modeSel | input | 2 | 00 pass, 01 stretch pauses, 10 flush lag, 11 pass |
| outValid | output | 1 | Output sample strobe, one cycle after `inValid` |
| outData | output | DATA_W | Signed output sample |

## Verification
The hardest condition to reach from the ports is the full store. Insertion must stop there while a stretch still has zeros left to send, and the stored samples must still come out in order afterwards. The bench uses a store of 64 entries, so a single 80-zero stretch runs into the limit. A long stretch is then followed by loud traffic, and the lagged samples are compared one by one against a queue model. A near-miss pause is also built on purpose: 79 quiet samples are broken by a sample at magnitude 768 exactly. This shows that the threshold edge and the counter clearing each prevent a stretch.

// File: rtl/pause_stretch_pkg.sv
package pause_stretch_pkg;

  typedef enum logic [1:0] {
    MODE_PASS    = 2'b00,
    MODE_STRETCH = 2'b01,
    MODE_FLUSH   = 2'b10,
    MODE_PASS2   = 2'b11
  } modeT;

  // strobes from control to datapath
  typedef struct packed {
    logic wrEn;     // store the incoming sample
    logic rdAdv;    // consume the oldest stored sample
    logic bypass;   // nothing stored: forward the input
    logic zeroOut;  // emit an inserted zero
    logic flush;    // drop all lag
  } ctrlT;

endpackage

// File: rtl/pause_stretch_ctrl.sv
module pause_stretch_ctrl
  import pause_stretch_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 11,
  parameter int THRESH = 768,
  parameter int WIN    = 80
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     inValid,
  input  logic signed [DATA_W-1:0] inData,
  input  logic [1:0]               modeSel,
  output ctrlT                     ctrlBus,
  output logic [ADDR_W:0]          fillLevel
);
  localparam int RUN_W    = $clog2(WIN + 1);
  localparam int FILL_W   = ADDR_W + 1;
  localparam int MAX_FILL = (1 << ADDR_W) - 1;

  logic [DATA_W:0] extData;
  logic [DATA_W:0] magnitude;
  logic            isQuiet;
  logic            stretching;
  logic            flushing;
  logic            canInsert;
  logic            armNow;
  logic [RUN_W-1:0] runCnt;
  logic [RUN_W-1:0] credit;
  logic [FILL_W-1:0] fill;

  always_comb begin
    extData   = {inData[DATA_W-1], inData};
    magnitude = extData[DATA_W] ? (~extData + (DATA_W+1)'(1)) : extData;
    isQuiet   = magnitude < (DATA_W+1)'(THRESH);
  end

  assign stretching = (modeT'(modeSel) == MODE_STRETCH);
  assign flushing   = (modeT'(modeSel) == MODE_FLUSH);
  assign canInsert  = stretching && (credit != '0) && (fill < FILL_W'(MAX_FILL));
  assign armNow     = isQuiet && (runCnt == RUN_W'(WIN - 1));

  always_comb begin
    ctrlBus.wrEn    = inValid;
    ctrlBus.zeroOut = canInsert;
    ctrlBus.rdAdv   = inValid && !canInsert;
    ctrlBus.bypass  = flushing || (fill == '0);
    ctrlBus.flush   = flushing;
  end

  // quiet-run counter, saturating
  always_ff @(posedge clk) begin
    if (!rstN) runCnt <= '0;
    else if (inValid) begin
      if (!isQuiet)                     runCnt <= '0;
      else if (runCnt != RUN_W'(WIN))   runCnt <= runCnt + RUN_W'(1);
    end
  end

  // zeros still owed to the current pause
  always_ff @(posedge clk) begin
    if (!rstN || !stretching) credit <= '0;
    else if (inValid) begin
      if (armNow)         credit <= RUN_W'(WIN);
      else if (canInsert) credit <= credit - RUN_W'(1);
    end
  end

  // stored-sample count equals accumulated lag
  always_ff @(posedge clk) begin
    if (!rstN || flushing)       fill <= '0;
    else if (inValid && canInsert) fill <= fill + FILL_W'(1);
  end

  assign fillLevel = fill;

endmodule

// File: rtl/pause_stretch_datapath.sv
module pause_stretch_datapath
  import pause_stretch_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 11
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  ctrlT                     ctrlBus,
  input  logic signed [DATA_W-1:0] inData,
  output logic                     outValid,
  output logic signed [DATA_W-1:0] outData
);
  localparam int DEPTH = 1 << ADDR_W;

  logic signed [DATA_W-1:0] store [DEPTH];
  logic [ADDR_W-1:0] wrPtr;
  logic [ADDR_W-1:0] rdPtr;
  logic signed [DATA_W-1:0] nextOut;

  always_comb begin
    if (ctrlBus.zeroOut)     nextOut = '0;
    else if (ctrlBus.bypass) nextOut = inData;
    else                     nextOut = store[rdPtr];
  end

  always_ff @(posedge clk) begin
    if (ctrlBus.wrEn) store[wrPtr] <= inData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr    <= '0;
      rdPtr    <= '0;
      outValid <= 1'b0;
      outData  <= '0;
    end else begin
      outValid <= ctrlBus.wrEn;
      if (ctrlBus.wrEn) begin
        outData <= nextOut;
        wrPtr   <= wrPtr + ADDR_W'(1);
      end
      if (ctrlBus.flush)
        rdPtr <= wrPtr + (ctrlBus.wrEn ? ADDR_W'(1) : ADDR_W'(0));
      else if (ctrlBus.wrEn && ctrlBus.rdAdv)
        rdPtr <= rdPtr + ADDR_W'(1);
    end
  end

endmodule

// File: rtl/pause_stretcher.sv
module pause_stretcher
  import pause_stretch_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 11,
  parameter int THRESH = 768,
  parameter int WIN    = 80
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     inValid,
  input  logic signed [DATA_W-1:0] inData,
  input  logic [1:0]               modeSel,
  output logic                     outValid,
  output logic signed [DATA_W-1:0] outData
);
  ctrlT            ctrlBus;
  logic [ADDR_W:0] fillLevel;
  logic            insertActive;

  assign insertActive = ctrlBus.zeroOut;

  pause_stretch_ctrl #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .THRESH(THRESH), .WIN(WIN)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData),
    .modeSel(modeSel), .ctrlBus(ctrlBus), .fillLevel(fillLevel)
  );

  pause_stretch_datapath #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctrlBus(ctrlBus), .inData(inData),
    .outValid(outValid), .outData(outData)
  );

endmodule

// File: rtl/pause_stretcher_checker.sv
module pause_stretcher_checker #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 11
) (
  input logic                     clk,
  input logic                     rstN,
  input logic                     inValid,
  input logic signed [DATA_W-1:0] inData,
  input logic [1:0]               modeSel,
  input logic                     outValid,
  input logic signed [DATA_W-1:0] outData,
  input logic                     insertActive,
  input logic [ADDR_W:0]          fillLevel
);
  localparam int MAX_FILL = (1 << ADDR_W) - 1;

  assert_one_out_per_in_R1: assert property (@(posedge clk) disable iff (!rstN)
    outValid == $past(inValid));

  assert_direct_pass_R2: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && fillLevel == '0 && modeSel != 2'b01) |=> outData == $past(inData));

  assert_inserted_zero_R5: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && insertActive) |=> outData == '0);

  assert_lag_only_on_insert_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!(inValid && insertActive) && modeSel != 2'b10) |=> $stable(fillLevel));

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rstN)
    fillLevel <= (ADDR_W+1)'(MAX_FILL));

  assert_flush_clears_R8: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel == 2'b10) |=> fillLevel == '0);

endmodule

bind pause_stretcher pause_stretcher_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData), .modeSel(modeSel),
  .outValid(outValid), .outData(outData), .insertActive(insertActive),
  .fillLevel(fillLevel)
);

// File: tb/pause_stretcher_bench.sv
module pause_stretcher_bench;
  localparam int DW    = 16;
  localparam int AW    = 6;
  localparam int DEPTH = 1 << AW;
  localparam int MAXF  = DEPTH - 1;
  localparam int WIN   = 80;
  localparam int TH    = 768;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic signed [DW-1:0] inData = '0;
  logic [1:0] modeSel = 2'b00;
  logic outValid;
  logic signed [DW-1:0] outData;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 0;
  string tag = "R1";

  // reference model state
  logic signed [DW-1:0] q [DEPTH];
  int qHead = 0;
  int qCnt = 0;
  int mRun = 0;
  int mCredit = 0;

  always #2 clk = ~clk;

  pause_stretcher #(.DATA_W(DW), .ADDR_W(AW), .THRESH(TH), .WIN(WIN)) u_pause_stretcher (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData),
    .modeSel(modeSel), .outValid(outValid), .outData(outData)
  );

  function automatic bit quiet(input logic signed [DW-1:0] x);
    int m;
    m = (x < 0) ? -int'(x) : int'(x);
    return m < TH;
  endfunction

  function automatic logic signed [DW-1:0] modelStep(input logic signed [DW-1:0] x,
                                                     input logic [1:0] m);
    logic signed [DW-1:0] e;
    bit ins;
    bit qs;
    if (m == 2'b10) begin qCnt = 0; mCredit = 0; end
    ins = (m == 2'b01) && (mCredit > 0) && (qCnt < MAXF);
    qs  = quiet(x);
    if (ins) begin
      e = '0;
      q[(qHead + qCnt) % DEPTH] = x;
      qCnt++;
    end else if (qCnt == 0) begin
      e = x;
    end else begin
      e = q[qHead];
      q[(qHead + qCnt) % DEPTH] = x;
      qHead = (qHead + 1) % DEPTH;
    end
    if (m != 2'b01) mCredit = 0;
    else if (qs && mRun == WIN - 1) mCredit = WIN;
    else if (ins) mCredit--;
    if (!qs) mRun = 0;
    else if (mRun < WIN) mRun++;
    return e;
  endfunction

  task automatic check(input bit ok, input int act, input int exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic send(input logic signed [DW-1:0] x, input logic [1:0] m);
    logic signed [DW-1:0] e;
    @(negedge clk);
    inValid = 1'b1; inData = x; modeSel = m;
    e = modelStep(x, m);
    @(negedge clk);
    inValid = 1'b0;
    check(outValid === 1'b1, int'(outValid), 1);
    check(outData === e, int'(outData), int'(e));
  endtask

  function automatic logic signed [DW-1:0] rndQuiet();
    return DW'($urandom_range(0, 2*(TH-1))) - DW'(TH-1);
  endfunction

  function automatic logic signed [DW-1:0] rndLoud();
    logic signed [DW-1:0] v;
    v = DW'($urandom());
    if (quiet(v)) v = 16'sd1000;
    return v;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      testsFailed++;
      testsRun++;
      $display("FAIL watchdog expired in %s", tag);
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    tag = "R1";
    check(outValid === 1'b0 && outData === '0, int'(outData), 0);
    rstN = 1'b1;
    @(negedge clk);

    tag = "R2";
    for (int i = 0; i < 20; i++) send(DW'($urandom()), 2'b00);

    tag = "R3";
    send(16'sd1000, 2'b01);
    for (int i = 0; i < 79; i++) send(rndQuiet(), 2'b01);
    send(16'sd768, 2'b01);
    for (int i = 0; i < 78; i++) send(rndQuiet(), 2'b01);
    send(-16'sd767, 2'b01);
    send(-16'sd768, 2'b01);
    for (int i = 0; i < 78; i++) send(rndQuiet(), 2'b01);
    send(16'sd767, 2'b01);

    tag = "R4";
    send(16'sd0, 2'b01);
    tag = "R5";
    for (int i = 0; i < 30; i++) send(rndLoud(), 2'b01);
    tag = "R9";
    for (int i = 0; i < 5; i++) send(rndLoud(), 2'b00);
    tag = "R6";
    for (int i = 0; i < 40; i++) send(rndLoud(), 2'b01);
    for (int i = 0; i < 10; i++) send(rndQuiet(), 2'b11);

    tag = "R8";
    send(16'sd4321, 2'b10);
    for (int i = 0; i < 5; i++) send(DW'($urandom()), 2'b11);

    tag = "R7";
    for (int i = 0; i < 85; i++) send(rndQuiet(), 2'b01);
    for (int i = 0; i < 100; i++) send(rndLoud(), 2'b01);
    for (int i = 0; i < 90; i++) send(rndQuiet(), 2'b01);
    for (int i = 0; i < 30; i++) send(rndLoud(), 2'b00);
    send(-16'sd5, 2'b10);

    tag = "R5";
    for (int i = 0; i < 4000; i++) begin
      logic [1:0] m;
      int r;
      r = $urandom_range(0, 99);
      m = (r < 2) ? 2'b10 : (r < 10) ? 2'b00 : (r < 12) ? 2'b11 : 2'b01;
      send(($urandom_range(0, 9) < 8) ? rndQuiet() : rndLoud(), m);
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule